// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts where a taken branch will go, using only its fetch address. Each cycle the fetch stage may present a program-counter value. A few address bits above the instruction-alignment bits pick one set. The remaining upper bits form a tag, which is compared against every way of that set in parallel. On a match, the block registers a prediction: a valid flag, the target address stored for that branch and a small branch-kind code. Fetch can then redirect to that target speculatively. A miss gives no prediction, and fetch carries on sequentially.

Resolved branches come back from execute on a separate update port. Only branches that were actually taken are written. A resolved branch whose tag already sits in its set refreshes that entry in place. A new branch takes the lowest-numbered empty way of its set. When the set is full, a tree pseudo-LRU policy picks the way to replace. Address width, target width, kind width, alignment, set count and way count are all parameters.

Top module: `branch_target_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pred_valid` is low, and every entry is empty, so the first lookup of any address after reset is a miss.
- R2: A lookup presented with `lk_en` high at one clock edge produces its result after that edge. `pred_valid` is high exactly when some valid way of set `lk_pc[ALIGN +: IDX_W]` holds tag `lk_pc[PC_W-1 : ALIGN+IDX_W]`.
- R3: On a hit, `pred_target` and `pred_kind` equal the target and kind last written for the matching entry.
- R4: When `lk_en` is low at an edge, `pred_valid` is low after that edge.
- R5: An update with `upd_en` and `upd_taken` both high takes effect for lookups presented from the next edge onward. A lookup presented in the same cycle still sees the table as it was before the write.
- R6: An update with `upd_taken` low changes nothing: no entry, no target and no replacement state.
- R7: An update whose tag already hits in its set overwrites that way's target and kind. No second copy is allocated, and no other entry of the set is evicted.
- R8: An allocation fills the lowest-numbered invalid way of the set before any valid way is replaced.
- R9: In a full set, the victim is chosen with a binary tree of WAYS-1 bits per set. Node n has children 2n+1 and 2n+2, and the root is node 0. A bit value of 0 sends the victim search to the lower-numbered half, and 1 sends it to the higher-numbered half.
- R10: The tree bits of a way are set to point away from that way on every lookup hit and every taken update. If both happen in one cycle, the lookup's change is applied first and the update's second. The victim is chosen from the bits held before that cycle's changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | A lookup is requested this cycle |
| lk_pc | input | PC_W | Fetch address to look up |
| pred_valid | output | 1 | Registered hit flag |
| pred_target | output | TGT_W | Registered predicted target |
| pred_kind | output | KIND_W | Registered branch-kind code |
| upd_en | input | 1 | A resolved branch is presented |
| upd_taken | input | 1 | The resolved branch was taken |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | TGT_W | Resolved target address |
| upd_kind | input | KIND_W | Branch-kind code to store |

## Verification
Some properties are checked by assertions on every cycle:
- The prediction is cleared by reset.
- No prediction follows an idle cycle.
- A not-taken update never reaches the write port.
- A written entry is valid and holds the written tag on the next cycle.
- No set ever holds two valid copies of one tag.

Other behaviour can only be shown by the bench's scenarios, because it depends on the contents of the table over many cycles:
- The exact way chosen as victim under pseudo-LRU.
- Filling invalid ways before evicting a valid one.
- In-place refresh without eviction.
- The ordering of a lookup and an update that fall in the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned DEF_KIND_W = 2;

  typedef enum logic [DEF_KIND_W-1:0] {
    BK_COND   = 2'd0,
    BK_DIRECT = 2'd1,
    BK_CALL   = 2'd2,
    BK_RETURN = 2'd3
  } br_kind_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned TAG_W  = 24,
  parameter int unsigned TGT_W  = 32,
  parameter int unsigned KIND_W = 2,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [IDX_W-1:0]                  rd0_set,
  output logic [WAYS-1:0]                   rd0_valid,
  output logic [WAYS-1:0][TAG_W-1:0]        rd0_tag,
  output logic [WAYS-1:0][TGT_W-1:0]        rd0_tgt,
  output logic [WAYS-1:0][KIND_W-1:0]       rd0_kind,
  input  logic [IDX_W-1:0]                  rd1_set,
  output logic [WAYS-1:0]                   rd1_valid,
  output logic [WAYS-1:0][TAG_W-1:0]        rd1_tag,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_set,
  input  logic [WAY_W-1:0]                  wr_way,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic [TGT_W-1:0]                  wr_tgt,
  input  logic [KIND_W-1:0]                 wr_kind
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [TGT_W-1:0]  tgt_q   [SETS][WAYS];
  logic [KIND_W-1:0] kind_q  [SETS][WAYS];

  always_comb begin
    rd0_valid = valid_q[rd0_set];
    rd1_valid = valid_q[rd1_set];
    for (int w = 0; w < WAYS; w++) begin
      rd0_tag[w]  = tag_q[rd0_set][w];
      rd0_tgt[w]  = tgt_q[rd0_set][w];
      rd0_kind[w] = kind_q[rd0_set][w];
      rd1_tag[w]  = tag_q[rd1_set][w];
    end
  end

  // valid bits: the only state that needs a reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  // payload: write-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      tgt_q[wr_set][wr_way]  <= wr_tgt;
      kind_q[wr_set][wr_way] <= wr_kind;
    end
  end

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_set)][$past(wr_way)] &&
               tag_q[$past(wr_set)][$past(wr_way)] == $past(wr_tag)));
endmodule

// File: rtl/btb_way_match.sv
module btb_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/btb_plru.sv
module btb_plru #(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_touch,
  input  logic [IDX_W-1:0] lk_set,
  input  logic [WAY_W-1:0] lk_way,
  input  logic             up_touch,
  input  logic [IDX_W-1:0] up_set,
  input  logic [WAY_W-1:0] up_way,
  input  logic [IDX_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);
  logic [NODES-1:0] bits_q [SETS];
  logic [NODES-1:0] bits_d [SETS];
  logic [SETS-1:0]  set_en;

  function automatic logic [NODES-1:0] point_away(input logic [NODES-1:0] b,
                                                  input logic [WAY_W-1:0] w);
    int   n;
    logic d;
    n = 0;
    for (int l = 0; l < WAY_W; l++) begin
      d    = w[WAY_W-1-l];
      b[n] = ~d;
      n    = 2 * n + 1 + int'(d);
    end
    return b;
  endfunction

  function automatic logic [WAY_W-1:0] walk(input logic [NODES-1:0] b);
    int n;
    n = 0;
    for (int l = 0; l < WAY_W; l++) begin
      n = 2 * n + 1 + int'(b[n]);
    end
    return WAY_W'(n - int'(NODES));
  endfunction

  assign vic_way = walk(bits_q[vic_set]);

  // next state: lookup touch first, update touch second
  always_comb begin
    for (int s = 0; s < SETS; s++) bits_d[s] = bits_q[s];
    set_en = '0;
    if (lk_touch) begin
      bits_d[lk_set] = point_away(bits_d[lk_set], lk_way);
      set_en[lk_set] = 1'b1;
    end
    if (up_touch) begin
      bits_d[up_set] = point_away(bits_d[up_set], up_way);
      set_en[up_set] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (set_en[s]) bits_q[s] <= bits_d[s];
      end
    end
  end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned TGT_W  = 32,
  parameter int unsigned KIND_W = btb_pkg::DEF_KIND_W,
  parameter int unsigned ALIGN  = 2,
  parameter int unsigned SETS   = 64,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned TAG_W = PC_W - ALIGN - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_valid,
  output logic [TGT_W-1:0]  pred_target,
  output logic [KIND_W-1:0] pred_kind,
  input  logic              upd_en,
  input  logic              upd_taken,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [TGT_W-1:0]  upd_target,
  input  logic [KIND_W-1:0] upd_kind
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             unused_align_bits;

  assign lk_idx = lk_pc[ALIGN +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_idx = upd_pc[ALIGN +: IDX_W];
  assign up_tag = upd_pc[PC_W-1 -: TAG_W];
  assign unused_align_bits = ^{lk_pc[ALIGN-1:0], upd_pc[ALIGN-1:0]};

  logic [WAYS-1:0]              lk_valid, up_valid;
  logic [WAYS-1:0][TAG_W-1:0]   lk_tags, up_tags;
  logic [WAYS-1:0][TGT_W-1:0]   lk_tgts;
  logic [WAYS-1:0][KIND_W-1:0]  lk_kinds;

  logic             wr_en;
  logic [WAY_W-1:0] wr_way;

  btb_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TGT_W(TGT_W), .KIND_W(KIND_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_set  (lk_idx),
    .rd0_valid(lk_valid),
    .rd0_tag  (lk_tags),
    .rd0_tgt  (lk_tgts),
    .rd0_kind (lk_kinds),
    .rd1_set  (up_idx),
    .rd1_valid(up_valid),
    .rd1_tag  (up_tags),
    .wr_en    (wr_en),
    .wr_set   (up_idx),
    .wr_way   (wr_way),
    .wr_tag   (up_tag),
    .wr_tgt   (upd_target),
    .wr_kind  (upd_kind)
  );

  logic [WAYS-1:0]  lk_hit_vec, up_hit_vec;
  logic             lk_hit, up_hit;
  logic [WAY_W-1:0] lk_way, up_hit_way;

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid  (lk_valid),
    .tags   (lk_tags),
    .key    (lk_tag),
    .hit_vec(lk_hit_vec),
    .hit    (lk_hit),
    .hit_way(lk_way)
  );

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .valid  (up_valid),
    .tags   (up_tags),
    .key    (up_tag),
    .hit_vec(up_hit_vec),
    .hit    (up_hit),
    .hit_way(up_hit_way)
  );

  // lowest-numbered empty way of the update set
  logic             has_free;
  logic [WAY_W-1:0] free_way;
  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!up_valid[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  logic [WAY_W-1:0] victim_way;
  logic             lk_touch;

  assign lk_touch = lk_en && lk_hit;
  assign wr_en    = upd_en && upd_taken;

  always_comb begin
    if (up_hit)        wr_way = up_hit_way;
    else if (has_free) wr_way = free_way;
    else               wr_way = victim_way;
  end

  btb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_touch(lk_touch),
    .lk_set  (lk_idx),
    .lk_way  (lk_way),
    .up_touch(wr_en),
    .up_set  (up_idx),
    .up_way  (wr_way),
    .vic_set (up_idx),
    .vic_way (victim_way)
  );

  // registered prediction
  logic              pred_valid_d;
  logic [TGT_W-1:0]  pred_target_d;
  logic [KIND_W-1:0] pred_kind_d;

  always_comb begin
    pred_valid_d  = lk_touch;
    pred_target_d = lk_tgts[lk_way];
    pred_kind_d   = lk_kinds[lk_way];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_valid <= 1'b0;
    else        pred_valid <= pred_valid_d;
  end

  always_ff @(posedge clk) begin
    if (pred_valid_d) begin
      pred_target <= pred_target_d;
      pred_kind   <= pred_kind_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pred_valid);

  // R4
  idle_no_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !pred_valid);

  // R6
  ignore_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken) |-> !wr_en);

  // R7
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ($countones(up_hit_vec) <= 1));
endmodule

// File: tb/branch_target_buffer_test.sv
`timescale 1ns/1ps
module branch_target_buffer_test;
  localparam int PC_W = 16, TGT_W = 16, KIND_W = 2, ALIGN = 2, SETS = 4, WAYS = 4;
  localparam int IDX_W = 2, TAG_W = PC_W - ALIGN - IDX_W, NODES = WAYS - 1, LVL = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lk_en, upd_en, upd_taken;
  logic [PC_W-1:0]   lk_pc, upd_pc;
  logic [TGT_W-1:0]  upd_target;
  logic [KIND_W-1:0] upd_kind;
  logic              pred_valid;
  logic [TGT_W-1:0]  pred_target;
  logic [KIND_W-1:0] pred_kind;

  always #4 clk = ~clk;

  branch_target_buffer #(
    .PC_W(PC_W), .TGT_W(TGT_W), .KIND_W(KIND_W), .ALIGN(ALIGN), .SETS(SETS), .WAYS(WAYS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_target(pred_target), .pred_kind(pred_kind),
    .upd_en(upd_en), .upd_taken(upd_taken), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_kind(upd_kind)
  );

  int checks = 0;
  int failures = 0;

  // reference model
  logic              m_valid [SETS][WAYS];
  logic [TAG_W-1:0]  m_tag   [SETS][WAYS];
  logic [TGT_W-1:0]  m_tgt   [SETS][WAYS];
  logic [KIND_W-1:0] m_kind  [SETS][WAYS];
  logic [NODES-1:0]  m_tree  [SETS];

  function automatic logic [PC_W-1:0] mk_pc(input int tag, input int set);
    return PC_W'((tag << (ALIGN + IDX_W)) | (set << ALIGN));
  endfunction

  function automatic logic [NODES-1:0] m_away(input logic [NODES-1:0] b, input int w);
    int n = 0;
    for (int l = 0; l < LVL; l++) begin
      int d = (w >> (LVL - 1 - l)) & 1;
      b[n] = (d == 0);
      n = 2 * n + 1 + d;
    end
    return b;
  endfunction

  function automatic int m_victim(input logic [NODES-1:0] b);
    int n = 0;
    for (int l = 0; l < LVL; l++) n = 2 * n + 1 + int'(b[n]);
    return n - NODES;
  endfunction

  function automatic int m_find(input int s, input logic [TAG_W-1:0] t);
    for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  logic              e_valid;
  logic [TGT_W-1:0]  e_tgt;
  logic [KIND_W-1:0] e_kind;

  task automatic check(input string req, input logic a_v, input logic x_v,
                       input logic [TGT_W-1:0] a_t, input logic [TGT_W-1:0] x_t,
                       input logic [KIND_W-1:0] a_k, input logic [KIND_W-1:0] x_k);
    checks++;
    if (a_v !== x_v || (x_v && (a_t !== x_t || a_k !== x_k))) begin
      failures++;
      $display("FAIL %s: got valid=%0b tgt=%h kind=%0d, expected valid=%0b tgt=%h kind=%0d",
               req, a_v, a_t, a_k, x_v, x_t, x_k);
    end
  endtask

  // one cycle: drive, predict, clock, compare with model
  task automatic step(input logic le, input logic [PC_W-1:0] lp,
                      input logic ue, input logic ut, input logic [PC_W-1:0] up,
                      input logic [TGT_W-1:0] tg, input logic [KIND_W-1:0] kd,
                      input string req);
    int ls, us, lw, uw, vic;
    logic [NODES-1:0] old_tree;
    lk_en = le; lk_pc = lp; upd_en = ue; upd_taken = ut;
    upd_pc = up; upd_target = tg; upd_kind = kd;
    ls = int'(lp[ALIGN +: IDX_W]);
    us = int'(up[ALIGN +: IDX_W]);
    lw = m_find(ls, lp[PC_W-1 -: TAG_W]);
    e_valid = le && (lw >= 0);
    e_tgt = '0; e_kind = '0;
    if (e_valid) begin e_tgt = m_tgt[ls][lw]; e_kind = m_kind[ls][lw]; end
    old_tree = m_tree[us];
    if (e_valid) m_tree[ls] = m_away(m_tree[ls], lw);
    if (ue && ut) begin
      uw = m_find(us, up[PC_W-1 -: TAG_W]);
      if (uw < 0) begin
        for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[us][w]) uw = w;
      end
      if (uw < 0) begin
        vic = m_victim(old_tree);
        uw = vic;
      end
      m_valid[us][uw] = 1'b1;
      m_tag[us][uw] = up[PC_W-1 -: TAG_W];
      m_tgt[us][uw] = tg;
      m_kind[us][uw] = kd;
      m_tree[us] = m_away(m_tree[us], uw);
    end
    @(posedge clk);
    @(negedge clk);
    check(req, pred_valid, e_valid, pred_target, e_tgt, pred_kind, e_kind);
  endtask

  task automatic look(input int t, input int s, input string req);
    step(1'b1, mk_pc(t, s), 1'b0, 1'b0, '0, '0, '0, req);
  endtask

  task automatic put(input int t, input int s, input int tg, input int kd, input string req);
    step(1'b0, '0, 1'b1, 1'b1, mk_pc(t, s), TGT_W'(tg), KIND_W'(kd), req);
  endtask

  task automatic expect_hand(input logic v, input int tg, input int kd, input string req);
    check(req, pred_valid, v, pred_target, TGT_W'(tg), pred_kind, KIND_W'(kd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got running, expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < SETS; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < WAYS; w++) m_valid[s][w] = 1'b0;
    end
    rst_n = 1'b0; lk_en = 0; lk_pc = '0; upd_en = 0; upd_taken = 0;
    upd_pc = '0; upd_target = '0; upd_kind = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_hand(1'b0, 0, 0, "R1 reset");
    look(1, 0, "R1 empty after reset");
    expect_hand(1'b0, 0, 0, "R1 first lookup misses");

    // R5: same-cycle update invisible, next cycle visible
    step(1'b1, mk_pc(1, 0), 1'b1, 1'b1, mk_pc(1, 0), 16'h0100, 2'd1, "R5 same cycle");
    expect_hand(1'b0, 0, 0, "R5 same-cycle lookup misses");
    step(1'b1, mk_pc(1, 0), 1'b1, 1'b1, mk_pc(2, 0), 16'h0200, 2'd2, "R5 next cycle");
    expect_hand(1'b1, 16'h0100, 1, "R3 R5 hit target and kind");
    put(3, 0, 16'h0300, 0, "R8 fill");
    put(4, 0, 16'h0400, 3, "R8 fill");
    // R9: all full, tree points at way 0 (tag 1)
    put(5, 0, 16'h0500, 1, "R9 evict");
    look(1, 0, "R9 oldest evicted");
    expect_hand(1'b0, 0, 0, "R9 tag1 evicted");
    look(2, 0, "R10 touch way1");
    expect_hand(1'b1, 16'h0200, 2, "R3 tag2 hit");
    put(6, 0, 16'h0600, 0, "R10 evict after touch");
    look(3, 0, "R10 way2 evicted");
    expect_hand(1'b0, 0, 0, "R10 tag3 evicted");
    look(4, 0, "R9 tag4 survives");
    expect_hand(1'b1, 16'h0400, 3, "R9 tag4 hit");

    // R7 refresh in place
    put(4, 0, 16'h0777, 3, "R7 refresh");
    look(4, 0, "R7 new target");
    expect_hand(1'b1, 16'h0777, 3, "R7 refreshed entry");
    look(2, 0, "R7 no eviction");  expect_hand(1'b1, 16'h0200, 2, "R7 tag2 kept");
    look(5, 0, "R7 no eviction");  expect_hand(1'b1, 16'h0500, 1, "R7 tag5 kept");
    look(6, 0, "R7 no eviction");  expect_hand(1'b1, 16'h0600, 0, "R7 tag6 kept");

    // R6 not-taken ignored
    step(1'b0, '0, 1'b1, 1'b0, mk_pc(9, 0), 16'h0999, 2'd0, "R6 new not-taken");
    step(1'b0, '0, 1'b1, 1'b0, mk_pc(2, 0), 16'h0abc, 2'd0, "R6 known not-taken");
    look(9, 0, "R6 not stored");   expect_hand(1'b0, 0, 0, "R6 tag9 absent");
    look(2, 0, "R6 target kept");  expect_hand(1'b1, 16'h0200, 2, "R6 tag2 unchanged");

    // R4 idle lookup
    step(1'b0, mk_pc(2, 0), 1'b0, 1'b0, '0, '0, '0, "R4 idle");
    expect_hand(1'b0, 0, 0, "R4 no prediction when idle");

    // R8 invalid ways first even after hits
    put(1, 3, 16'h3001, 0, "R8 set3");
    look(1, 3, "R8 touch"); look(1, 3, "R8 touch");
    put(2, 3, 16'h3002, 0, "R8 set3");
    put(3, 3, 16'h3003, 0, "R8 set3");
    put(4, 3, 16'h3004, 0, "R8 set3");
    look(1, 3, "R8 first entry kept"); expect_hand(1'b1, 16'h3001, 0, "R8 tag1 in set3");
    look(2, 3, "R8 second kept");      expect_hand(1'b1, 16'h3002, 0, "R8 tag2 in set3");

    // random phase: R2 R3 R5 R6 R7 R8 R9 R10 against model
    for (int i = 0; i < 4000; i++) begin
      logic le, ue, ut;
      int lt, ls2, ut2, us2;
      le  = ($urandom % 4) != 0;
      ue  = ($urandom % 3) == 0;
      ut  = ($urandom % 5) != 0;
      lt  = int'($urandom % 8); ls2 = int'($urandom % SETS);
      ut2 = int'($urandom % 8); us2 = int'($urandom % SETS);
      if (($urandom % 4) == 0) begin ut2 = lt; us2 = ls2; end
      step(le, mk_pc(lt, ls2) | PC_W'($urandom % 4), ue, ut,
           mk_pc(ut2, us2) | PC_W'($urandom % 4),
           TGT_W'($urandom), KIND_W'($urandom), "R2 random lookup");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule